// File: doc/BRIEF.md
# Mixed-Radix FFT Twiddle Address Generator

This block turns the stage counter of an in-place mixed-radix FFT into read addresses for a twiddle-factor table. The table holds the N powers W^i = exp(-j2πi/N), i = 0 … N-1, in ascending order of i. The FFT size is N = R1^S1 × R2^S2. The first S2 stages are radix-R2 and the last S1 stages are radix-R1, so there are S = S1 + S2 stages in all.

On every cycle that `in_valid` is high, the block takes the current stage number and the mixed-radix digits of the shared stage counter. It returns the table address for the operand that the operand-address path fetches in that same cycle. The exponent is built without any modulo operation. The block forms a weighted sum of the upper counter digits, read in reversed digit order. It multiplies that sum by a stage-dependent scale and then by the low digit C0, which is the operand's index inside the butterfly.

The result appears a fixed `PIPE_STAGES` cycles later. The operand path must carry the same number of registers so that both addresses reach the datapath together.

Top module: `mrtw_twiddle_agen`

## Requirements
- R1: When `in_stage` is 1, the address is 0 for every operand.
- R2: When digit C0 is 0, the address is 0 at every stage.
- R3: Stage m is encoded in binary as 1 … S on `in_stage`. Digit Ci sits at `in_acc[i*DW +: DW]`. The address is C0 × c(S-m) × Σ_{i=0}^{m-2} c'(i)·C(S-1-i). Here c(i) = R1^i for i ≤ S1, else R1^S1·R2^(i-S1). Likewise c'(i) = R2^i for i ≤ S2, else R2^S2·R1^(i-S2).
- R4: At stage m, the digits C1 … C(S-m) do not affect the address.
- R5: For N = 12 (R1=3, S1=1, R2=2, S2=2), stage 2 counts its digits as C2 radix 2, C1 radix 3 and C0 radix 2, with C0 fastest. The twelve addresses are then 0,0,0,0,0,0,0,3,0,3,0,3.
- R6: For the same N = 12, stage 3 counts C2 radix 2, C1 radix 2 and C0 radix 3. The twelve addresses are 0,0,0,0,2,4,0,1,2,0,3,6.
- R7: Every address output with `out_valid` high is below N.
- R8: `out_valid` equals `in_valid` delayed by exactly `PIPE_STAGES` cycles. Idle input cycles give idle output cycles.
- R9: While `rst_n` is low, `out_valid` and `out_addr` are 0.
- R10: The stage number may change between any two consecutive valid cycles. Each output then uses the stage given with its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Stage and counter digits are valid this cycle |
| in_stage | input | SW | Stage number, 1 … S |
| in_acc | input | S*DW | Counter digits, Ci at bits [i*DW +: DW] |
| out_valid | output | 1 | Address valid, PIPE_STAGES cycles after input |
| out_addr | output | AW | Twiddle table address |

## Verification
Two things can land in one cycle: a change of stage, and a change in the upper counter digits that feed the reversed weighted sum. With the split pipeline, one operand's scale can be selected while the next operand's sum is being formed. The bench drives streams in which the stage changes every cycle, mixed with idle gaps. It compares each output against a queued reference exponent, computed modulo N from the stage and digits. The fixed stage-2 and stage-3 tables are replayed, and the unused middle digit is swept to confirm that it has no effect.

// File: rtl/mrtw_pkg.sv
package mrtw_pkg;

   // Integer power b**e, used for constant weights.
   function automatic int ipow(input int b, input int e);
      int r;
      r = 1;
      for (int k = 0; k < e; k++) r = r * b;
      return r;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Weight of time-index digit i (radix-R1 digits low, radix-R2 above).
   function automatic int in_weight(input int i, input int r1, input int r2, input int s1);
      if (i <= s1) return ipow(r1, i);
      return ipow(r1, s1) * ipow(r2, i - s1);
   endfunction

   // Weight of frequency-index digit i (radix-R2 digits low, radix-R1 above).
   function automatic int out_weight(input int i, input int r1, input int r2, input int s2);
      if (i <= s2) return ipow(r2, i);
      return ipow(r2, s2) * ipow(r1, i - s2);
   endfunction

   // Butterfly radix used at stage m (1-based).
   function automatic int stage_radix(input int m, input int r1, input int r2, input int s2);
      return (m <= s2) ? r2 : r1;
   endfunction

endpackage

// File: rtl/mrtw_beta.sv
// Reversed-digit weighted sum: sum over i < m-1 of c'(i) * C(S-1-i).
module mrtw_beta
   import mrtw_pkg::*;
#(
   parameter int R1 = 3,
   parameter int R2 = 2,
   parameter int S1 = 1,
   parameter int S2 = 2,
   parameter int DW = 2,
   parameter int AW = 4,
   parameter int SW = 2
) (
   input  logic [SW-1:0]        stage,
   input  logic [(S1+S2)*DW-1:0] acc,
   output logic [AW-1:0]        beta_p
);
   localparam int S     = S1 + S2;
   localparam int NTERM = S - 1;

   logic [AW-1:0] terms [NTERM];

   genvar gi;
   generate
      for (gi = 0; gi < NTERM; gi++) begin : g_term
         localparam logic [AW-1:0] WT = AW'(out_weight(gi, R1, R2, S2));
         logic [DW-1:0] dig;
         assign dig = acc[(S-1-gi)*DW +: DW];
         // Digit gi of the reversed counter joins once stage >= gi+2 (R4 masks the rest).
         assign terms[gi] = (stage >= SW'(gi + 2)) ? AW'(dig) * WT : '0;
      end
   endgenerate

   always_comb begin
      beta_p = '0;
      for (int k = 0; k < NTERM; k++) beta_p = beta_p + terms[k];
   end

endmodule

// File: rtl/mrtw_scale.sv
// Stage scale c(S-m) and operand index multiply; no modulo needed.
module mrtw_scale
   import mrtw_pkg::*;
#(
   parameter int R1 = 3,
   parameter int R2 = 2,
   parameter int S1 = 1,
   parameter int S2 = 2,
   parameter int DW = 2,
   parameter int AW = 4,
   parameter int SW = 2
) (
   input  logic [SW-1:0] stage,
   input  logic [DW-1:0] tdig,
   input  logic [AW-1:0] beta_p,
   output logic [AW-1:0] addr
);
   localparam int S = S1 + S2;

   logic [AW-1:0] scale_tab [1:S];
   logic [AW-1:0] scale;
   logic [AW-1:0] beta_s;

   genvar gm;
   generate
      for (gm = 1; gm <= S; gm++) begin : g_scale
         assign scale_tab[gm] = AW'(in_weight(S - gm, R1, R2, S1));
      end
   endgenerate

   always_comb begin
      scale = '0;
      for (int m = 1; m <= S; m++) begin
         if (stage == SW'(m)) scale = scale_tab[m];
      end
   end

   assign beta_s = beta_p * scale;
   assign addr   = beta_s * AW'(tdig);

endmodule

// File: rtl/mrtw_twiddle_agen.sv
module mrtw_twiddle_agen
   import mrtw_pkg::*;
#(
   parameter int R1          = 3,
   parameter int R2          = 2,
   parameter int S1          = 1,
   parameter int S2          = 2,
   parameter int PIPE_STAGES = 2,
   localparam int S  = S1 + S2,
   localparam int N  = ipow(R1, S1) * ipow(R2, S2),
   localparam int DW = (imax(R1, R2) > 2) ? $clog2(imax(R1, R2)) : 1,
   localparam int AW = (N > 2) ? $clog2(N) : 1,
   localparam int SW = $clog2(S + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [SW-1:0] in_stage,
   input  logic [S*DW-1:0] in_acc,
   output logic          out_valid,
   output logic [AW-1:0] out_addr
);

   // Elaboration-time parameter checks
   generate
      if (R1 < 2 || R2 < 2) begin : g_bad_radix
         $error("mrtw_twiddle_agen: radices must be at least 2");
      end
      if (S < 2 || S1 < 0 || S2 < 0) begin : g_bad_stages
         $error("mrtw_twiddle_agen: need at least two stages");
      end
      if (PIPE_STAGES < 1 || PIPE_STAGES > 2) begin : g_bad_pipe
         $error("mrtw_twiddle_agen: PIPE_STAGES must be 1 or 2");
      end
   endgenerate

   logic [AW-1:0] beta_w;
   logic [DW-1:0] t_in;
   assign t_in = in_acc[DW-1:0];

   mrtw_beta #(
      .R1(R1), .R2(R2), .S1(S1), .S2(S2), .DW(DW), .AW(AW), .SW(SW)
   ) u_beta (
      .stage  (in_stage),
      .acc    (in_acc),
      .beta_p (beta_w)
   );

   // Middle of the pipe: registered (split) or direct (flat)
   logic          mid_valid;
   logic [SW-1:0] mid_stage;
   logic [DW-1:0] mid_t;
   logic [AW-1:0] mid_beta;

   generate
      if (PIPE_STAGES == 2) begin : g_split
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mid_valid <= 1'b0;
               mid_stage <= '0;
               mid_t     <= '0;
               mid_beta  <= '0;
            end else begin
               mid_valid <= in_valid;
               if (in_valid) begin
                  mid_stage <= in_stage;
                  mid_t     <= t_in;
                  mid_beta  <= beta_w;
               end
            end
         end
      end else begin : g_flat
         assign mid_valid = in_valid;
         assign mid_stage = in_stage;
         assign mid_t     = t_in;
         assign mid_beta  = beta_w;
      end
   endgenerate

   logic [AW-1:0] addr_w;

   mrtw_scale #(
      .R1(R1), .R2(R2), .S1(S1), .S2(S2), .DW(DW), .AW(AW), .SW(SW)
   ) u_scale (
      .stage  (mid_stage),
      .tdig   (mid_t),
      .beta_p (mid_beta),
      .addr   (addr_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= mid_valid;
         if (mid_valid) out_addr <= addr_w;
      end
   end

   // Input legality (R3 encoding)
   a_r3_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_stage >= SW'(1) && int'(in_stage) <= S));
   a_r3_digit_legal: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (int'(t_in) < stage_radix(int'(in_stage), R1, R2, S2)));

   // Output behaviour
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, PIPE_STAGES));
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_addr) < N));
   a_r1_stage1_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_stage, PIPE_STAGES) == SW'(1)) |-> (out_addr == '0));
   a_r2_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_acc[DW-1:0], PIPE_STAGES) == '0) |-> (out_addr == '0));

endmodule

// File: tb/mrtw_twiddle_agen_bench.sv
`timescale 1ns/1ps
module mrtw_twiddle_agen_bench;
   localparam int N   = 12;
   localparam int LAT = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_stage = '0;
   logic [5:0] in_acc = '0;
   logic       out_valid;
   logic [3:0] out_addr;

   always #2.5 clk = ~clk;

   mrtw_twiddle_agen u_mrtw_twiddle_agen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stage(in_stage),
      .in_acc(in_acc), .out_valid(out_valid), .out_addr(out_addr)
   );

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   bit    q_v[$];
   int    q_a[$];
   string q_tag[$];
   int    seed = 7;

   // Digit radix of Ci at stage m for the 12-point case
   function automatic int rad(input int m, input int i);
      if (m == 3) return (i == 0) ? 3 : 2;
      return (i == 1) ? 3 : 2;
   endfunction

   // Reference exponent: k-part * c(S-m) * n(S-m), reduced mod N
   function automatic int ref_exp(input int m, input int d2, input int d1, input int d0);
      int kp, sc;
      kp = 0;
      if (m >= 2) kp = kp + d2;
      if (m >= 3) kp = kp + 2 * d1;
      sc = (m == 1) ? 6 : (m == 2) ? 3 : 1;
      return (kp * sc * d0) % N;
   endfunction

   function automatic int nxt();
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      return seed >>> 8;
   endfunction

   task automatic check_out();
      bit    ev;
      int    ea;
      string et;
      ev = q_v.pop_front();
      ea = q_a.pop_front();
      et = q_tag.pop_front();
      checks++;
      if (out_valid !== ev) begin
         failures++;
         $display("FAIL %s R8 out_valid=%0b expected=%0b", et, out_valid, ev);
      end else if (ev) begin
         checks++;
         if (int'(out_addr) != ea) begin
            failures++;
            $display("FAIL %s out_addr=%0d expected=%0d", et, out_addr, ea);
         end
         checks++;
         if (int'(out_addr) >= N) begin
            failures++;
            $display("FAIL R7 out_addr=%0d expected below %0d", out_addr, N);
         end
      end
   endtask

   task automatic step(input bit v, input int m, input int d2, input int d1,
                       input int d0, input int ea, input string tag);
      @(negedge clk);
      check_out();
      in_valid = v;
      in_stage = 2'(m);
      in_acc   = 6'((d2 << 4) | (d1 << 2) | d0);
      q_v.push_back(v);
      q_a.push_back(ea);
      q_tag.push_back(tag);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int tab2 [12] = '{0,0,0,0,0,0,0,3,0,3,0,3};
      int tab3 [12] = '{0,0,0,0,2,4,0,1,2,0,3,6};
      // R9: reset state
      in_valid = 1'b1;
      in_stage = 2'd2;
      in_acc   = 6'b010001;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_addr !== 4'd0) begin
         failures++;
         $display("FAIL R9 out_valid=%0b out_addr=%0d expected 0/0", out_valid, out_addr);
      end
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < LAT; k++) begin
         q_v.push_back(1'b0); q_a.push_back(0); q_tag.push_back("R9");
      end

      // R1: stage 1 sweep, all zero
      for (int n = 0; n < 12; n++) begin
         int r0, r1;
         r0 = rad(1, 0); r1 = rad(1, 1);
         step(1'b1, 1, n / (r0 * r1), (n / r0) % r1, n % r0, 0, "R1");
      end
      // R5: stage 2 table
      for (int n = 0; n < 12; n++) begin
         int r0, r1;
         r0 = rad(2, 0); r1 = rad(2, 1);
         step(1'b1, 2, n / (r0 * r1), (n / r0) % r1, n % r0, tab2[n], "R5");
      end
      // R6: stage 3 table
      for (int n = 0; n < 12; n++) begin
         int r0, r1;
         r0 = rad(3, 0); r1 = rad(3, 1);
         step(1'b1, 3, n / (r0 * r1), (n / r0) % r1, n % r0, tab3[n], "R6");
      end
      // R4: middle digit C1 unused at stage 2
      for (int d1 = 0; d1 < 3; d1++) step(1'b1, 2, 1, d1, 1, 3, "R4");
      for (int d1 = 0; d1 < 3; d1++) step(1'b1, 2, 0, d1, 1, 0, "R4");
      // R8: idle gaps between valid cycles
      for (int k = 0; k < 6; k++) begin
         step(1'b1, 3, 1, 1, 2, ref_exp(3, 1, 1, 2), "R8");
         step(1'b0, 3, 1, 1, 1, 0, "R8");
         if (k % 2 == 0) step(1'b0, 1, 0, 0, 0, 0, "R8");
      end
      // R2: zero operand index at every stage
      for (int m = 1; m <= 3; m++) step(1'b1, m, 1, 1, 0, 0, "R2");
      // R3 R10: stage changes every cycle with random legal digits
      for (int k = 0; k < 300; k++) begin
         int m, d0, d1, d2;
         bit v;
         m  = 1 + nxt() % 3;
         d0 = nxt() % rad(m, 0);
         d1 = nxt() % rad(m, 1);
         d2 = nxt() % rad(m, 2);
         v  = (nxt() % 8) != 0;
         step(v, m, d2, d1, d0, ref_exp(m, d2, d1, d0),
              (m == 1) ? "R1 R10" : (d0 == 0) ? "R2 R10" : "R3 R10");
      end
      for (int k = 0; k < LAT + 1; k++) step(1'b0, 1, 0, 0, 0, 0, "R8");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule